// File: doc/BRIEF.md
# Watchdog Timer with Locked Prewarning Window

This block supervises software liveness. A prescaler divides the clock into watchdog ticks, and a main counter advances one step per tick from a programmable reload value towards all-ones. Software must write a refresh strobe before the main counter overflows. A refresh reloads the main counter and also clears the prescaler, so every period that follows a refresh is exactly full length.

If the main counter overflows, the block raises a non-maskable interrupt request and enters a prewarning window of fixed length, counted in ticks. Refresh writes have no effect in that window, and disabling the watchdog has no effect there either. When the window ends, the block pulses a reset request for one cycle and returns to the disabled state. For debugging, the whole count (prescaler and main counter) can be frozen while a debug-mode signal is high. This only happens if software has set the suspend-enable bit.

All pins are plain control and status pins. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `wdog_prewarn_top`

## Requirements
- R1: After reset, `nmi_req_o` and `rst_req_o` are low and `state_o` reads 0. The state encoding is 0 = disabled, 1 = counting, 2 = prewarning, 3 = reset request.
- R2: When `enable_i` is high in the disabled state, the next edge enters counting with the main counter loaded from `reload_i` and the prescaler at zero. Overflow follows 2^CNT_W − reload ticks of 2^PRESC_W cycles each, that is, that many clock edges after the entry edge. On the overflow edge `nmi_req_o` rises and `state_o` becomes 2.
- R3: A refresh accepted while counting reloads the main counter and clears the prescaler on the same edge. Overflow then occurs one full period after that edge.
- R4: The prewarning window lasts PW_TICKS ticks (default 48). On the edge that ends the window, `state_o` becomes 3 and `rst_req_o` is high for exactly one cycle. The next edge returns the block to state 0.
- R5: Refresh strobes during prewarning are ignored. The state, `nmi_req_o` and the time of the reset request are unchanged even with `refresh_i` held high throughout.
- R6: When `susp_en_i` and `debug_i` are both high, the prescaler and main counter hold their values, so no overflow occurs. `debug_i` alone does not stop the count.
- R7: A refresh while the count is frozen clears the prescaler and reloads the main counter. After `debug_i` falls, overflow takes a full period.
- R8: Dropping `enable_i` while counting returns the block to state 0 on the next edge, and no interrupt follows. Dropping it during prewarning has no effect.
- R9: `nmi_req_o` stays high, including after the reset request, until `nmi_ack_i` is seen high on a clock edge, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Watchdog enable |
| refresh_i | input | 1 | Refresh strobe, one cycle per write |
| reload_i | input | CNT_W | Main counter start value |
| susp_en_i | input | 1 | Allow freezing the count in debug mode |
| debug_i | input | 1 | Debug mode active |
| nmi_ack_i | input | 1 | Acknowledge that clears the interrupt request |
| nmi_req_o | output | 1 | Non-maskable interrupt request |
| rst_req_o | output | 1 | One-cycle system reset request |
| state_o | output | 2 | Current state (encoding in R1) |

## Verification
A bad state decode or a stale counter shows up at the ports as a shifted overflow edge or a shifted reset pulse. The bench therefore samples `nmi_req_o` and `rst_req_o` exactly one cycle before and one cycle after the predicted edge. A prescaler that is not cleared by a refresh while frozen shortens the first period after resume by the residual prescaler value, which the bench exposes as an early interrupt. A refresh that leaks into prewarning, or a disable that does, moves or removes the reset pulse 48 ticks later, or changes `state_o` at once.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WD_OFF     = 2'd0,
    WD_RUN     = 2'd1,
    WD_PREWARN = 2'd2,
    WD_RSTREQ  = 2'd3
  } wd_state_e;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRESC_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  input  logic hold_i,
  output logic tick_o
);
  logic [PRESC_W-1:0] div_q;
  logic               adv;

  assign adv    = run_i && !hold_i;
  assign tick_o = adv && (&div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (clr_i)  div_q <= '0;
    else if (adv)    div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/wdog_main_counter.sv
module wdog_main_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             step_i,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;

  assign ovf_o = step_i && (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load_i)           cnt_q <= reload_i;
    else if (step_i && !ovf_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_prewarn_timer.sv
module wdog_prewarn_timer #(
  parameter int PW_TICKS = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic step_i,
  output logic done_o
);
  localparam int PW_W = (PW_TICKS > 1) ? $clog2(PW_TICKS) : 1;
  localparam logic [PW_W-1:0] LAST = PW_W'(PW_TICKS - 1);

  logic [PW_W-1:0] pw_q;

  assign done_o = step_i && (pw_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pw_q <= '0;
    else if (clr_i)             pw_q <= '0;
    else if (step_i && !done_o) pw_q <= pw_q + 1'b1;
  end
endmodule

// File: rtl/wdog_prewarn_top.sv
module wdog_prewarn_top
  import wdog_pkg::*;
#(
  parameter int PRESC_W  = 4,
  parameter int CNT_W    = 8,
  parameter int PW_TICKS = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             refresh_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             susp_en_i,
  input  logic             debug_i,
  input  logic             nmi_ack_i,
  output logic             nmi_req_o,
  output logic             rst_req_o,
  output logic [1:0]       state_o
);
  wd_state_e st_q, st_d;
  logic frozen, refresh_ok, tick, ovf, pw_done;
  logic in_off, in_run, in_pw, go_prewarn, nmi_q;

  assign in_off     = (st_q == WD_OFF);
  assign in_run     = (st_q == WD_RUN);
  assign in_pw      = (st_q == WD_PREWARN);
  assign frozen     = susp_en_i && debug_i;
  assign refresh_ok = refresh_i && in_run;
  assign go_prewarn = in_run && enable_i && ovf;

  wdog_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (!(in_run || in_pw) || refresh_ok),
    .run_i  (in_run || in_pw),
    .hold_i (frozen),
    .tick_o (tick)
  );

  wdog_main_counter #(.CNT_W(CNT_W)) u_main (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (in_off || refresh_ok),
    .reload_i (reload_i),
    .step_i   (tick && in_run),
    .ovf_o    (ovf)
  );

  wdog_prewarn_timer #(.PW_TICKS(PW_TICKS)) u_pw (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (!in_pw),
    .step_i (tick && in_pw),
    .done_o (pw_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      WD_OFF:     if (enable_i) st_d = WD_RUN;
      WD_RUN: begin
        if (!enable_i) st_d = WD_OFF;
        else if (ovf)  st_d = WD_PREWARN;
      end
      WD_PREWARN: if (pw_done) st_d = WD_RSTREQ;
      WD_RSTREQ:  st_d = WD_OFF;
      default:    st_d = WD_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WD_OFF;
      nmi_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (go_prewarn)     nmi_q <= 1'b1;
      else if (nmi_ack_i) nmi_q <= 1'b0;
    end
  end

  assign nmi_req_o = nmi_q;
  assign rst_req_o = (st_q == WD_RSTREQ);
  assign state_o   = st_q;
endmodule

// File: rtl/wdog_prewarn_checker.sv
module wdog_prewarn_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       enable_i,
  input logic       susp_en_i,
  input logic       debug_i,
  input logic       nmi_ack_i,
  input logic       nmi_req_o,
  input logic       rst_req_o,
  input logic [1:0] state_o
);
  assert_rst_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> (!rst_req_o && state_o == 2'd0));

  assert_rst_after_prewarn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> ($past(state_o) == 2'd2));

  assert_nmi_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_req_o) |-> (state_o == 2'd2));

  assert_prewarn_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2) |=> (state_o == 2'd2 || state_o == 2'd3));

  assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_en_i && debug_i && enable_i && state_o == 2'd1) |=> (state_o == 2'd1));

  assert_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_ack_i && state_o != 2'd1) |=> !nmi_req_o);
endmodule

bind wdog_prewarn_top wdog_prewarn_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable_i  (enable_i),
  .susp_en_i (susp_en_i),
  .debug_i   (debug_i),
  .nmi_ack_i (nmi_ack_i),
  .nmi_req_o (nmi_req_o),
  .rst_req_o (rst_req_o),
  .state_o   (state_o)
);

// File: tb/wdog_prewarn_top_tb.sv
module wdog_prewarn_top_tb;
  localparam int PRESC_W = 4;
  localparam int CNT_W   = 8;
  localparam int PW      = 48;
  localparam int TICK    = 1 << PRESC_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable_i = 1'b0, refresh_i = 1'b0, susp_en_i = 1'b0, debug_i = 1'b0, nmi_ack_i = 1'b0;
  logic [CNT_W-1:0] reload_i = '0;
  logic nmi_req_o, rst_req_o;
  logic [1:0] state_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  wdog_prewarn_top #(.PRESC_W(PRESC_W), .CNT_W(CNT_W), .PW_TICKS(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .refresh_i(refresh_i),
    .reload_i(reload_i), .susp_en_i(susp_en_i), .debug_i(debug_i),
    .nmi_ack_i(nmi_ack_i), .nmi_req_o(nmi_req_o), .rst_req_o(rst_req_o),
    .state_o(state_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int period(input int r);
    return TICK * ((1 << CNT_W) - r);
  endfunction

  task automatic do_reset();
    enable_i = 0; refresh_i = 0; susp_en_i = 0; debug_i = 0; nmi_ack_i = 0;
    rst_n = 0;
    step(2);
    rst_n = 1;
    step(1);
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 nmi", int'(nmi_req_o), 0);
    check("R1 rst_req", int'(rst_req_o), 0);
    check("R1 state", int'(state_o), 0);
  endtask

  task automatic t_overflow(input int r);
    do_reset();
    reload_i = CNT_W'(r);
    enable_i = 1;
    step(1);
    check("R2 entry state", int'(state_o), 1);
    step(period(r) - 1);
    check("R2 nmi before overflow", int'(nmi_req_o), 0);
    step(1);
    check("R2 nmi at overflow", int'(nmi_req_o), 1);
    check("R2 state prewarn", int'(state_o), 2);
  endtask

  task automatic t_refresh();
    do_reset();
    reload_i = 8'hFC;
    enable_i = 1;
    step(45);
    refresh_i = 1;
    step(1);
    refresh_i = 0;
    step(period(8'hFC) - 1);
    check("R3 no overflow before full period", int'(nmi_req_o), 0);
    step(1);
    check("R3 overflow after full period", int'(nmi_req_o), 1);
  endtask

  task automatic t_prewarn();
    do_reset();
    reload_i = 8'hFC;
    enable_i = 1;
    step(period(8'hFC) + 1);
    check("R2 nmi set", int'(nmi_req_o), 1);
    enable_i = 0;    // R8: ignored in prewarning
    refresh_i = 1;   // R5: ignored in prewarning
    step(TICK * PW - 1);
    check("R5 state still prewarn", int'(state_o), 2);
    check("R5 nmi held", int'(nmi_req_o), 1);
    check("R4 no reset before window end", int'(rst_req_o), 0);
    step(1);
    check("R4 reset request pulse", int'(rst_req_o), 1);
    check("R8 disable ignored, state", int'(state_o), 3);
    refresh_i = 0;
    step(1);
    check("R4 single-cycle pulse", int'(rst_req_o), 0);
    check("R4 back to off", int'(state_o), 0);
    check("R9 nmi kept after reset request", int'(nmi_req_o), 1);
    nmi_ack_i = 1;
    step(1);
    nmi_ack_i = 0;
    check("R9 ack clears nmi", int'(nmi_req_o), 0);
  endtask

  task automatic t_suspend();
    do_reset();
    reload_i = 8'hFC;
    susp_en_i = 0;
    debug_i = 1;
    enable_i = 1;
    step(period(8'hFC));
    check("R6 debug alone does not freeze (before)", int'(nmi_req_o), 0);
    step(1);
    check("R6 debug alone does not freeze", int'(nmi_req_o), 1);

    do_reset();
    reload_i = 8'hFC;
    susp_en_i = 1;
    enable_i = 1;
    step(11);
    debug_i = 1;
    step(300);
    check("R6 frozen no overflow", int'(nmi_req_o), 0);
    check("R6 frozen state", int'(state_o), 1);
    refresh_i = 1;
    step(1);
    refresh_i = 0;
    step(200);
    check("R7 still frozen", int'(nmi_req_o), 0);
    debug_i = 0;
    step(period(8'hFC) - 1);
    check("R7 full period after resume (before)", int'(nmi_req_o), 0);
    step(1);
    check("R7 overflow after full period", int'(nmi_req_o), 1);
  endtask

  task automatic t_disable();
    do_reset();
    reload_i = 8'hFC;
    enable_i = 1;
    step(30);
    enable_i = 0;
    step(1);
    check("R8 disable returns to off", int'(state_o), 0);
    step(200);
    check("R8 no nmi after disable", int'(nmi_req_o), 0);
    check("R8 stays off", int'(state_o), 0);
  endtask

  initial begin
    t_reset_state();
    t_overflow(8'hFC);
    t_overflow(8'hF8);
    t_overflow(8'hFF);
    t_refresh();
    t_prewarn();
    t_suspend();
    t_disable();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule